// File: doc/BRIEF.md
# Security-Filtering Bridge from a Single-Beat AXI Slave to APB

This block takes single-beat read and write requests from a simplified AXI slave port and replays them on an APB master port. The APB port serves a fixed number of peripheral slots, and each slot has its own select line. The APB side carries no security indication at all, so this bridge is the only place where the Secure/Non-secure split between peripherals is enforced. A per-slot attribute input (`slot_secure`, from a register or from strap pins) marks each slot as Secure (1) or Non-secure (0).

Every request is first decoded to a slot. The bridge then judges the request using bit 1 of its protection field before any APB cycle starts. A Non-secure request aimed at a Secure slot is answered by the bridge itself and never reaches the peripheral. The same holds for an address that maps to no slot. A parameter selects how a refused access is answered: a silent OKAY, a slave error or a decode error. The bridge handles one transaction at a time, and its AXI ready signals stay low until the current response has been taken.

The address map is as follows. The slot index is `addr[SLOT_LSB +: SLOT_W]`. The bits above the slot field must equal `REGION_TAG`. With the defaults this gives slot = `addr[14:12]`, `addr[15]` must be 0, and there are 6 slots.

Top module: `secfilt_apb_bridge`

## Requirements
- R1: After reset, every `psel` bit is 0, `penable` is 0, `bvalid`/`rvalid` are 0, and `awready`/`wready`/`arready` are 0 while no valid is driven.
- R2: Bit 1 of `awprot`/`arprot` gives the security of the request (0 = Secure, 1 = Non-secure). A Secure request reaches any mapped slot. A Non-secure request reaches a slot whose `slot_secure` bit is 0.
- R3: A Non-secure request to a slot whose `slot_secure` bit is 1 never raises any `psel`. It is answered according to `DENY_MODE`: 0 gives OKAY (2'b00) with zero read data and a dropped write, 1 gives SLVERR (2'b10), and 2 gives DECERR (2'b11). The default is 1.
- R4: An address whose slot index is `NSLOT` or more, or whose bits above the slot field differ from `REGION_TAG`, raises no `psel` and is answered with DECERR (2'b11) and zero read data.
- R5: A forwarded access raises only the addressed slot's `psel` for exactly one cycle with `penable` low. It then holds `penable` high with `psel`, `paddr`, `pwrite` and `pwdata` unchanged until that slot's `pready` is 1. The response becomes valid in the cycle after that.
- R6: A forwarded access answers SLVERR (2'b10) when the slot's `pslverr` is 1 in the completing cycle, and OKAY (2'b00) otherwise. Read data is the slot's `prdata` from that cycle. A forwarded write presents `wdata`/`wstrb` on `pwdata`/`pstrb`.
- R7: From the accepting clock edge until the response handshake completes, `awready`, `wready` and `arready` stay 0.
- R8: When a complete write (`awvalid` and `wvalid`) and a read (`arvalid`) are both pending in the idle state, the write is accepted first and the read is accepted after the write response completes.
- R9: `awready` and `wready` are raised together, and only when `awvalid` and `wvalid` are both 1. A lone `awvalid` is not accepted.
- R10: A refused request's response is valid in the cycle right after acceptance. Any response stays valid with a stable code until `bready`/`rready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_secure | input | NSLOT | Per-slot attribute, 1 = Secure slot |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awaddr | input | ADDR_W | Write address |
| awprot | input | 3 | Write protection; bit 1 set = Non-secure |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | DATA_W | Write data |
| wstrb | input | DATA_W/8 | Write byte strobes |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bresp | output | 2 | Write response code |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| araddr | input | ADDR_W | Read address |
| arprot | input | 3 | Read protection; bit 1 set = Non-secure |
| rvalid | output | 1 | Read response valid |
| rready | input | 1 | Read response ready |
| rdata | output | DATA_W | Read data |
| rresp | output | 2 | Read response code |
| psel | output | NSLOT | Per-slot APB select |
| penable | output | 1 | APB enable (access phase) |
| pwrite | output | 1 | APB direction |
| paddr | output | ADDR_W | APB address |
| pwdata | output | DATA_W | APB write data |
| pstrb | output | DATA_W/8 | APB write strobes, zero on reads |
| prdata | input | NSLOT*DATA_W | Per-slot read data, slot i at bits i*DATA_W |
| pready | input | NSLOT | Per-slot ready |
| pslverr | input | NSLOT | Per-slot error |

## Verification
A wrong decision latched at acceptance shows up on the first cycle after the accepting edge. A refused request that wrongly forwards lights a `psel` bit in that cycle. A permitted request that is wrongly refused raises `bvalid`/`rvalid` two or more cycles early. A corrupted slot index or a stuck sequencer state shows up as a wrong select line or a missing enable one cycle later, or as a response whose latency differs from three cycles plus the peripheral wait. A dropped busy condition shows up at once as a ready accepting a second request while the first is still in flight.

// File: rtl/secfilt_pkg.sv
package secfilt_pkg;

  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_EXOKAY = 2'b01,
    RESP_SLVERR = 2'b10,
    RESP_DECERR = 2'b11
  } axi_resp_e;

  typedef enum logic [1:0] {
    VERD_FWD   = 2'd0,
    VERD_DENY  = 2'd1,
    VERD_UNMAP = 2'd2
  } verdict_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2,
    ST_RESP   = 2'd3
  } bstate_e;

  localparam int DENY_SILENT = 0;
  localparam int DENY_SLVERR = 1;
  localparam int DENY_DECERR = 2;

endpackage

// File: rtl/secfilt_decode.sv
module secfilt_decode #(
  parameter int ADDR_W     = 16,
  parameter int NSLOT      = 6,
  parameter int SLOT_LSB   = 12,
  parameter int SLOT_W     = 3,
  parameter int REGION_TAG = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [SLOT_W-1:0] slot
);
  localparam int TAG_W = ADDR_W - SLOT_LSB - SLOT_W;
  localparam logic [SLOT_W:0] NSLOT_L = (SLOT_W+1)'(NSLOT);

  logic tag_ok;

  assign slot = addr[SLOT_LSB +: SLOT_W];

  generate
    if (TAG_W > 0) begin : g_tag
      assign tag_ok = (addr[ADDR_W-1 -: TAG_W] == TAG_W'(REGION_TAG));
    end else begin : g_notag
      assign tag_ok = 1'b1;
    end
  endgenerate

  assign hit = tag_ok && ({1'b0, slot} < NSLOT_L);

endmodule

// File: rtl/secfilt_gate.sv
module secfilt_gate
  import secfilt_pkg::*;
#(
  parameter int NSLOT  = 6,
  parameter int SLOT_W = 3
) (
  input  logic              hit,
  input  logic [SLOT_W-1:0] slot,
  input  logic              nonsec,
  input  logic [NSLOT-1:0]  slot_secure,
  output verdict_e          verdict
);
  logic target_secure;

  always_comb begin
    target_secure = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      if (slot == SLOT_W'(i)) target_secure = slot_secure[i];
    end
  end

  always_comb begin
    if (!hit)                        verdict = VERD_UNMAP;
    else if (nonsec && target_secure) verdict = VERD_DENY;
    else                             verdict = VERD_FWD;
  end

endmodule

// File: rtl/secfilt_seq.sv
module secfilt_seq
  import secfilt_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int NSLOT     = 6,
  parameter int SLOT_W    = 3,
  parameter int DENY_MODE = DENY_SLVERR
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic                    req_nonsec,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  input  logic [DATA_W/8-1:0]     req_strb,
  input  verdict_e                req_verdict,
  input  logic [SLOT_W-1:0]       req_slot,
  input  logic [NSLOT-1:0]        slot_secure,
  output logic                    accept,
  output logic                    bvalid,
  input  logic                    bready,
  output logic                    rvalid,
  input  logic                    rready,
  output logic [1:0]              resp,
  output logic [DATA_W-1:0]       rdata,
  output logic [NSLOT-1:0]        psel,
  output logic                    penable,
  output logic                    pwrite,
  output logic [ADDR_W-1:0]       paddr,
  output logic [DATA_W-1:0]       pwdata,
  output logic [DATA_W/8-1:0]     pstrb,
  input  logic [NSLOT*DATA_W-1:0] prdata,
  input  logic [NSLOT-1:0]        pready,
  input  logic [NSLOT-1:0]        pslverr
);
  localparam int STRB_W = DATA_W / 8;
  localparam axi_resp_e DENY_RESP =
    (DENY_MODE == DENY_SILENT) ? RESP_OKAY :
    (DENY_MODE == DENY_DECERR) ? RESP_DECERR : RESP_SLVERR;

  bstate_e             state_q, state_d;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [STRB_W-1:0]   strb_q;
  logic                write_q, nonsec_q;
  logic [SLOT_W-1:0]   slot_q;
  logic [1:0]          resp_q, resp_d;
  logic [DATA_W-1:0]   rdata_q, rdata_d;
  logic                load_req, load_resp, apb_done, resp_taken;
  logic                sel_ready, sel_err;
  logic [DATA_W-1:0]   sel_rdata;

  // Completion signals of the addressed slot
  always_comb begin
    sel_ready = 1'b0;
    sel_err   = 1'b0;
    sel_rdata = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (slot_q == SLOT_W'(i)) begin
        sel_ready = pready[i];
        sel_err   = pslverr[i];
        sel_rdata = prdata[i*DATA_W +: DATA_W];
      end
    end
  end

  assign accept     = (state_q == ST_IDLE) && req_valid;
  assign apb_done   = (state_q == ST_ACCESS) && sel_ready;
  assign resp_taken = (state_q == ST_RESP) && (write_q ? bready : rready);
  assign load_req   = accept;
  assign load_resp  = apb_done || (accept && (req_verdict != VERD_FWD));

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid) state_d = (req_verdict == VERD_FWD) ? ST_SETUP : ST_RESP;
      ST_SETUP:  state_d = ST_ACCESS;
      ST_ACCESS: if (sel_ready) state_d = ST_RESP;
      ST_RESP:   if (resp_taken) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // Response staging: local answer at acceptance or peripheral answer
  always_comb begin
    if (apb_done) begin
      resp_d  = sel_err ? RESP_SLVERR : RESP_OKAY;
      rdata_d = write_q ? '0 : sel_rdata;
    end else begin
      resp_d  = (req_verdict == VERD_UNMAP) ? RESP_DECERR : DENY_RESP;
      rdata_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (load_req) begin
      addr_q   <= req_addr;
      wdata_q  <= req_wdata;
      strb_q   <= req_strb;
      write_q  <= req_write;
      nonsec_q <= req_nonsec;
      slot_q   <= req_slot;
    end
    if (load_resp) begin
      resp_q  <= resp_d;
      rdata_q <= rdata_d;
    end
  end

  generate
    for (genvar g = 0; g < NSLOT; g++) begin : g_sel
      assign psel[g] = ((state_q == ST_SETUP) || (state_q == ST_ACCESS)) &&
                       (slot_q == SLOT_W'(g));
    end
  endgenerate

  assign penable = (state_q == ST_ACCESS);
  assign pwrite  = write_q;
  assign paddr   = addr_q;
  assign pwdata  = wdata_q;
  assign pstrb   = write_q ? strb_q : '0;
  assign bvalid  = (state_q == ST_RESP) && write_q;
  assign rvalid  = (state_q == ST_RESP) && !write_q;
  assign resp    = resp_q;
  assign rdata   = rdata_q;

  a_r5_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(psel));

  a_r5_setup_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ((|psel) && !penable) |=> (penable && $stable(psel) && $stable(paddr)));

  a_r5_access_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (penable && !sel_ready) |=> (penable && $stable(psel) && $stable(paddr) &&
                                 $stable(pwdata) && $stable(pwrite)));

  a_r3_no_ns_to_secure: assert property (@(posedge clk) disable iff (!rst_n)
    (|psel) |-> !(nonsec_q && |(psel & slot_secure)));

  a_r10_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((bvalid && !bready) || (rvalid && !rready)) |=>
      ((bvalid || rvalid) && $stable(resp)));

endmodule

// File: rtl/secfilt_apb_bridge.sv
module secfilt_apb_bridge
  import secfilt_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int NSLOT      = 6,
  parameter int SLOT_LSB   = 12,
  parameter int SLOT_W     = 3,
  parameter int REGION_TAG = 0,
  parameter int DENY_MODE  = DENY_SLVERR
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSLOT-1:0]        slot_secure,
  input  logic                    awvalid,
  output logic                    awready,
  input  logic [ADDR_W-1:0]       awaddr,
  input  logic [2:0]              awprot,
  input  logic                    wvalid,
  output logic                    wready,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [DATA_W/8-1:0]     wstrb,
  output logic                    bvalid,
  input  logic                    bready,
  output logic [1:0]              bresp,
  input  logic                    arvalid,
  output logic                    arready,
  input  logic [ADDR_W-1:0]       araddr,
  input  logic [2:0]              arprot,
  output logic                    rvalid,
  input  logic                    rready,
  output logic [DATA_W-1:0]       rdata,
  output logic [1:0]              rresp,
  output logic [NSLOT-1:0]        psel,
  output logic                    penable,
  output logic                    pwrite,
  output logic [ADDR_W-1:0]       paddr,
  output logic [DATA_W-1:0]       pwdata,
  output logic [DATA_W/8-1:0]     pstrb,
  input  logic [NSLOT*DATA_W-1:0] prdata,
  input  logic [NSLOT-1:0]        pready,
  input  logic [NSLOT-1:0]        pslverr
);
  logic              wr_pending, req_valid, req_nonsec, accept, hit;
  logic [ADDR_W-1:0] req_addr;
  logic [SLOT_W-1:0] req_slot;
  logic [1:0]        resp;
  verdict_e          verdict;
  logic              prot_unused;

  // Only the security bit of each protection field matters here
  assign prot_unused = ^{awprot[2], awprot[0], arprot[2], arprot[0]};

  // A complete write wins over a read when both wait in idle
  assign wr_pending = awvalid && wvalid;
  assign req_valid  = wr_pending || arvalid;
  assign req_addr   = wr_pending ? awaddr : araddr;
  assign req_nonsec = wr_pending ? awprot[1] : arprot[1];

  secfilt_decode #(
    .ADDR_W(ADDR_W), .NSLOT(NSLOT), .SLOT_LSB(SLOT_LSB),
    .SLOT_W(SLOT_W), .REGION_TAG(REGION_TAG)
  ) u_decode (
    .addr(req_addr), .hit(hit), .slot(req_slot)
  );

  secfilt_gate #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_gate (
    .hit(hit), .slot(req_slot), .nonsec(req_nonsec),
    .slot_secure(slot_secure), .verdict(verdict)
  );

  secfilt_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSLOT(NSLOT),
    .SLOT_W(SLOT_W), .DENY_MODE(DENY_MODE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(wr_pending), .req_nonsec(req_nonsec),
    .req_addr(req_addr), .req_wdata(wdata), .req_strb(wstrb),
    .req_verdict(verdict), .req_slot(req_slot), .slot_secure(slot_secure),
    .accept(accept),
    .bvalid(bvalid), .bready(bready), .rvalid(rvalid), .rready(rready),
    .resp(resp), .rdata(rdata),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata), .pready(pready),
    .pslverr(pslverr)
  );

  assign awready = accept && wr_pending;
  assign wready  = accept && wr_pending;
  assign arready = accept && !wr_pending;
  assign bresp   = resp;
  assign rresp   = resp;

  a_r7_busy_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid || rvalid || (|psel)) |-> !(awready || wready || arready));

  a_r9_write_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (awready || wready) |-> (awvalid && wvalid && awready && wready));

  a_r8_write_first: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && wvalid && arvalid && !bvalid && !rvalid && !(|psel)) |-> !arready);

endmodule

// File: tb/secfilt_apb_bridge_bench.sv
module secfilt_apb_bridge_bench;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NS = 6;
  localparam int SW = DW / 8;
  localparam logic [NS-1:0] MASK = 6'b100101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic awvalid = 0, wvalid = 0, arvalid = 0, bready = 0, rready = 0;
  logic [AW-1:0] awaddr = '0, araddr = '0;
  logic [2:0]    awprot = '0, arprot = '0;
  logic [DW-1:0] wdata = '0;
  logic [SW-1:0] wstrb = '0;
  logic awready, wready, arready, bvalid, rvalid, penable, pwrite;
  logic [1:0] bresp, rresp;
  logic [DW-1:0] rdata, pwdata;
  logic [SW-1:0] pstrb;
  logic [AW-1:0] paddr;
  logic [NS-1:0] psel, pready, pslverr;
  logic [NS*DW-1:0] prdata;

  int checks = 0, fails = 0;
  int wait_n = 0, acc_cnt = 0, sel_cycles = 0, wcount = 0;
  logic [AW-1:0] last_waddr;
  logic [DW-1:0] last_wdata;
  logic [SW-1:0] last_wstrb;

  always #10 clk = ~clk;

  secfilt_apb_bridge u_secfilt_apb_bridge (
    .clk(clk), .rst_n(rst_n), .slot_secure(MASK),
    .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awprot(awprot),
    .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb),
    .bvalid(bvalid), .bready(bready), .bresp(bresp),
    .arvalid(arvalid), .arready(arready), .araddr(araddr), .arprot(arprot),
    .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata), .pready(pready),
    .pslverr(pslverr)
  );

  function automatic logic [DW-1:0] slot_pattern(int s, logic [AW-1:0] a);
    return {8'h5A, 5'b0, 3'(s), a};
  endfunction

  // Peripheral models: common wait count, error on address bit 11
  always_comb begin
    for (int i = 0; i < NS; i++) prdata[i*DW +: DW] = slot_pattern(i, paddr);
  end
  assign pready  = {NS{penable && (acc_cnt == wait_n)}};
  assign pslverr = {NS{penable && paddr[11]}};

  always @(posedge clk) begin
    if (penable && !pready[0]) acc_cnt <= acc_cnt + 1;
    else                       acc_cnt <= 0;
    if (|psel) sel_cycles <= sel_cycles + 1;
    if ((|psel) && penable && (|(psel & pready)) && pwrite) begin
      wcount     <= wcount + 1;
      last_waddr <= paddr;
      last_wdata <= pwdata;
      last_wstrb <= pstrb;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_resp(bit ns, logic [AW-1:0] a);
    if (a[15] || a[14:12] > 3'd5) return 2'b11;
    if (ns && MASK[a[14:12]])      return 2'b10;
    return a[11] ? 2'b10 : 2'b00;
  endfunction

  function automatic bit exp_fwd(bit ns, logic [AW-1:0] a);
    if (a[15] || a[14:12] > 3'd5) return 1'b0;
    return !(ns && MASK[a[14:12]]);
  endfunction

  function automatic string tag_of(bit ns, logic [AW-1:0] a);
    if (a[15] || a[14:12] > 3'd5) return "R4";
    if (ns && MASK[a[14:12]])      return "R3";
    return "R6";
  endfunction

  task automatic run_txn(bit wr, bit ns, logic [AW-1:0] a, logic [DW-1:0] d,
                         logic [SW-1:0] st, int w);
    int lat, sel0, wc0;
    bit fwd;
    fwd = exp_fwd(ns, a);
    @(negedge clk);
    wait_n = w; bready = 1; rready = 1;
    sel0 = sel_cycles; wc0 = wcount;
    if (wr) begin
      awvalid = 1; wvalid = 1; awaddr = a; awprot = {1'b0, ns, 1'b0};
      wdata = d; wstrb = st;
    end else begin
      arvalid = 1; araddr = a; arprot = {1'b0, ns, 1'b0};
    end
    #1;
    while (!(wr ? awready : arready)) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    awvalid = 0; wvalid = 0; arvalid = 0;
    lat = 1;
    while (!(wr ? bvalid : rvalid)) begin
      if (fwd && lat == 1) begin
        chk("R5 setup select", {psel, penable}, {NS'(1 << a[14:12]), 1'b0});
        chk("R5 setup address", paddr, a);
      end
      if (fwd && lat == 2) chk("R5 access enable", {psel, penable}, {NS'(1 << a[14:12]), 1'b1});
      @(negedge clk);
      lat++;
    end
    chk({tag_of(ns, a), " response code"}, wr ? bresp : rresp, exp_resp(ns, a));
    chk({fwd ? "R5" : "R10", " response latency"}, lat, fwd ? 3 + w : 1);
    chk({fwd ? "R2" : tag_of(ns, a), " apb select cycles"}, sel_cycles - sel0, fwd ? 2 + w : 0);
    if (!wr) chk({tag_of(ns, a), " read data"}, rdata, fwd ? slot_pattern(a[14:12], a) : '0);
    if (wr && fwd) begin
      chk("R6 write count", wcount - wc0, 1);
      chk("R6 write fields", {last_waddr, last_wdata, last_wstrb}, {a, d, st});
    end
    if (wr && !fwd) chk({tag_of(ns, a), " write dropped"}, wcount - wc0, 0);
    @(posedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'd7177);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk); #1;
    chk("R1 reset selects", {psel, penable}, '0);
    chk("R1 reset responses", {bvalid, rvalid}, 2'b00);
    chk("R1 reset readies", {awready, wready, arready}, 3'b000);

    // R2: Secure reaches secure and non-secure slots, non-secure reaches non-secure
    run_txn(1, 0, 16'h0040, 32'hCAFE0001, 4'hF, 0);
    run_txn(0, 0, 16'h1084, 32'h0, 4'h0, 1);
    run_txn(0, 1, 16'h3010, 32'h0, 4'h0, 0);
    run_txn(1, 1, 16'h4020, 32'h12345678, 4'h5, 2);
    // R3: non-secure to secure slots
    run_txn(1, 1, 16'h2000, 32'hDEADBEEF, 4'hF, 0);
    run_txn(0, 1, 16'h5004, 32'h0, 4'h0, 0);
    // R4: unmapped addresses
    run_txn(0, 0, 16'h6000, 32'h0, 4'h0, 0);
    run_txn(1, 0, 16'h7008, 32'h1, 4'h1, 0);
    run_txn(0, 0, 16'h8000, 32'h0, 4'h0, 0);
    // R6: peripheral error, R5: long wait
    run_txn(0, 0, 16'h0800, 32'h0, 4'h0, 3);
    run_txn(1, 1, 16'h3800, 32'h55AA55AA, 4'hC, 1);

    // R9: lone write address is not accepted
    @(negedge clk);
    awvalid = 1; awaddr = 16'h1000; awprot = 3'b000; #1;
    chk("R9 lone awvalid awready", {awready, wready}, 2'b00);
    @(negedge clk); #1;
    chk("R9 lone awvalid still idle", {awready, wready, |psel}, 3'b000);
    awvalid = 0;
    run_txn(1, 0, 16'h1000, 32'hA5A5A5A5, 4'hF, 0);

    // R8: write and read together, write first
    @(negedge clk);
    wait_n = 0; bready = 1; rready = 1;
    awvalid = 1; wvalid = 1; awaddr = 16'h1010; awprot = 3'b010; wdata = 32'h0BADF00D; wstrb = 4'hF;
    arvalid = 1; araddr = 16'h3020; arprot = 3'b010; #1;
    chk("R8 write taken first", {awready, arready}, 2'b10);
    @(posedge clk);
    @(negedge clk); awvalid = 0; wvalid = 0; #1;
    chk("R7 read held while busy", arready, 1'b0);
    while (!bvalid) begin @(negedge clk); #1; chk("R7 read held while busy", arready, 1'b0); end
    chk("R8 write response", bresp, 2'b00);
    @(posedge clk);
    @(negedge clk); #1;
    chk("R8 read follows write", arready, 1'b1);
    @(posedge clk);
    @(negedge clk); arvalid = 0;
    while (!rvalid) @(negedge clk);
    chk("R8 read data", rdata, slot_pattern(3, 16'h3020));
    @(posedge clk);

    // R10: refused read response held under back-pressure
    @(negedge clk);
    rready = 0; arvalid = 1; araddr = 16'h0000; arprot = 3'b010; #1;
    @(posedge clk);
    @(negedge clk); arvalid = 0;
    for (int k = 0; k < 3; k++) begin
      chk("R10 held valid", {rvalid, rresp}, {1'b1, 2'b10});
      chk("R7 no ready during hold", arready, 1'b0);
      @(negedge clk);
    end
    rready = 1;
    @(posedge clk);
    @(negedge clk);
    chk("R10 released", rvalid, 1'b0);

    // Random mix
    for (int k = 0; k < 80; k++) begin
      logic [31:0] r;
      logic [AW-1:0] a;
      r = $urandom;
      a = {(r[7:5] == 3'd0), r[4:2], r[8], r[21:11]};
      run_txn(r[0], r[1], a, $urandom, r[25:22], int'(r[10:9]));
    end

    finish_run();
  end

endmodule